// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames as a byte stream and stores them in host memory buffers. Software describes those buffers with a ring of four-word descriptors that sit in the same memory. The engine reaches that memory through a simple word port: one request per cycle, writes always accepted, read data returned the cycle after the request. Software supplies the ring base address and a run level. It hands a descriptor to the engine by setting its ownership bit. It nudges a suspended engine with a one-cycle poll pulse.

The engine fetches a descriptor. If software owns it, the engine waits for a frame and packs the bytes little-endian into 32-bit words in the buffer. When the buffer fills, or the frame ends, it writes back the descriptor's first word with the segment flags, the error summary and the frame length, and clears the ownership bit. A frame longer than one buffer continues into the next descriptor. When the engine meets a descriptor it does not own, it suspends. Frames that arrive while it is suspended are accepted and dropped, and each dropped frame is counted. Each completed frame raises a sticky interrupt flag.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset the state code is 0, `rx_ready_o`, `mem_req_o` and `rx_irq_o` are low, and `missed_cnt_o` is 0. All of these hold until `run_i` is seen high.
- R2: When `run_i` is high in the stopped state, the engine latches `list_base_i`. It then reads the descriptor there, one word per cycle, at byte addresses base, base+4, base+8 and base+12.
- R3: Descriptor layout. Word0 bit 31 set means the engine owns the descriptor. Word1 bits 11:0 are the buffer size in bytes, bit 14 selects chained mode and bit 15 marks end of ring. Word2 is the buffer address and word3 is the next descriptor address. A buffer never receives more bytes than its size.
- R4: Received bytes are packed little-endian into words: the byte at buffer offset k goes to lane k mod 4 of the word at buffer address + (k & ~3). In a partly filled final word the unused lanes are zero.
- R5: Write-back replaces word0. Bit 31 becomes 0. Bit 9 is set if the buffer holds the first byte of the frame. Bit 8 is set if it holds the last byte. Only in that last case does bit 15 hold the OR of `rx_err_i` over the frame and bits 29:16 hold the frame length in bytes. All other bits are 0.
- R6: A frame longer than one buffer continues into the next owned descriptor. Only the first descriptor gets bit 9, and only the final one gets bit 8, the error bit and the length.
- R7: After a write-back, the next descriptor address is chosen in this order: the latched base if end of ring is set; otherwise word3 if chained mode is set; otherwise the current address + 16.
- R8: A fetched descriptor with bit 31 clear puts the engine into the suspended state. It stays there until a `poll_i` pulse, which re-reads the same descriptor address.
- R9: `state_o` codes: 0 stopped, 1 fetching descriptor, 3 waiting for a frame, 4 suspended, 5 closing descriptor, 7 writing frame data.
- R10: While suspended, bytes are accepted and discarded, and memory is not written. Each frame whose last byte is dropped adds one to `missed_cnt_o`, which saturates.
- R11: `rx_irq_o` rises after the write-back of a descriptor that carries the last flag. It stays high until `irq_clr_i` is pulsed.
- R12: With `run_i` low, the engine returns to the stopped state (code 0, `rx_ready_o` low). This happens from the waiting state when no byte is offered, or from the suspended state when no frame is being dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run enable level |
| poll_i | input | 1 | Poll-demand pulse |
| list_base_i | input | ADDR_W | Descriptor ring base byte address |
| rx_valid_i | input | 1 | Byte stream valid |
| rx_data_i | input | 8 | Byte stream data |
| rx_last_i | input | 1 | Last byte of frame |
| rx_err_i | input | 1 | Frame error indication, sampled with each byte |
| rx_ready_o | output | 1 | Engine accepts a byte this cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| state_o | output | 3 | Process state code |
| rx_irq_o | output | 1 | Receive-complete flag |
| irq_clr_i | input | 1 | Clears the receive-complete flag |
| missed_cnt_o | output | MISS_W | Dropped frame count |

## Verification
A wrong byte offset or a lost lane in the packer shows up as a corrupted or shifted buffer word. This is visible in memory as soon as the word is flushed, at most four bytes after the fault. An error in the segment or ring-walk state shows up in the next write-back: a flag, length or next-descriptor address goes wrong on the very next frame, and later frames land in the wrong buffers. A wrong ownership or suspend decision appears within a descriptor fetch (five cycles) as a wrong state code, as a buffer written while it should have been dropped, or as a missed count that disagrees with the number of dropped frames.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int BUF_SIZE_W  = 12;
  localparam int FRAME_LEN_W = 14;
  localparam int LEN_LSB     = 16;
  localparam int OWN_BIT     = 31;
  localparam int ERR_BIT     = 15;
  localparam int FIRST_BIT   = 9;
  localparam int LAST_BIT    = 8;
  localparam int CHAIN_BIT   = 14;
  localparam int EOR_BIT     = 15;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd3,
    ST_SUSP  = 3'd4,
    ST_CLOSE = 3'd5,
    ST_WRITE = 3'd7
  } rxd_state_e;

  function automatic logic [31:0] status_word(input logic first, input logic last,
                                              input logic err,
                                              input logic [FRAME_LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[FIRST_BIT] = first;
    if (last) begin
      w[LAST_BIT] = 1'b1;
      w[ERR_BIT]  = err;
      w[LEN_LSB +: FRAME_LEN_W] = len;
    end
    return w;
  endfunction
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int SIZE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic [7:0]        byte_i,
  input  logic              force_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic [31:0]       pend_data_o,
  output logic [SIZE_W-1:0] pend_off_o,
  output logic [SIZE_W-1:0] boff_o
);
  logic [SIZE_W-1:0] boff_q;
  logic [31:0]       word_q, merged;
  logic              pend_q;
  logic [1:0]        lane;
  logic              completes;

  assign lane      = boff_q[1:0];
  assign completes = take_i && ((lane == 2'd3) || force_i);

  always_comb begin
    merged = word_q;
    merged[{lane, 3'b000} +: 8] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boff_q      <= '0;
      word_q      <= '0;
      pend_q      <= 1'b0;
      pend_data_o <= '0;
      pend_off_o  <= '0;
    end else begin
      if (ack_i) pend_q <= 1'b0;
      if (clear_i) begin
        boff_q <= '0;
        word_q <= '0;
      end else if (take_i) begin
        boff_q <= boff_q + SIZE_W'(1);
        if (completes) begin
          pend_q      <= 1'b1;
          pend_data_o <= merged;
          pend_off_o  <= {boff_q[SIZE_W-1:2], 2'b00};
          word_q      <= '0;
        end else begin
          word_q <= merged;
        end
      end
    end
  end

  assign pend_o = pend_q;
  assign boff_o = boff_q;

  // R4: a finished word waits until the memory port takes it
  a_r4_pend_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i |=> pend_q);
  // R4: no finished word is overwritten before it is written out
  a_r4_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i |-> !completes);
endmodule

// File: rtl/rxd_events.sv
module rxd_events #(
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              clr_i,
  input  logic              miss_i,
  output logic              irq_o,
  output logic [MISS_W-1:0] missed_o
);
  logic              irq_q;
  logic [MISS_W-1:0] missed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      missed_q <= '0;
    end else begin
      if (done_i)     irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
      if (miss_i && !(&missed_q)) missed_q <= missed_q + MISS_W'(1);
    end
  end

  assign irq_o    = irq_q;
  assign missed_o = missed_q;

  a_r11_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_i |=> irq_q);
  a_r11_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_q && !done_i |=> !irq_q);
  a_r10_miss_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> $stable(missed_q));
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  poll_i,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic                  rx_valid_i,
  input  logic                  rx_last_i,
  input  logic                  rx_err_i,
  output logic                  rx_ready_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [31:0]           mem_wdata_o,
  input  logic [31:0]           mem_rdata_i,
  output logic [2:0]            state_o,
  output logic                  done_o,
  output logic                  miss_o,
  output logic                  pk_clear_o,
  output logic                  pk_take_o,
  output logic                  pk_force_o,
  output logic                  pk_ack_o,
  input  logic                  pk_pend_i,
  input  logic [31:0]           pk_data_i,
  input  logic [BUF_SIZE_W-1:0] pk_off_i,
  input  logic [BUF_SIZE_W-1:0] pk_boff_i
);
  rxd_state_e             state_q;
  logic [ADDR_W-1:0]      cur_q, base_q, buf_q, next_q, nxt_addr;
  logic [2:0]             idx_q;
  logic                   own_q, chain_q, eor_q;
  logic [BUF_SIZE_W-1:0]  size_q;
  logic                   in_frame_q, first_q, last_q, err_q, drop_q, poll_q;
  logic [FRAME_LEN_W-1:0] len_q;
  logic                   take, full, status_wr, drop_n;
  logic [31:0]            unused_w1;

  assign rx_ready_o = (state_q == ST_WAIT) || (state_q == ST_WRITE) || (state_q == ST_SUSP);
  assign take       = rx_valid_i && rx_ready_o;
  assign full       = (pk_boff_i + BUF_SIZE_W'(1)) == size_q;
  assign pk_take_o  = take && ((state_q == ST_WAIT) || (state_q == ST_WRITE));
  assign pk_force_o = pk_take_o && (rx_last_i || full);
  assign pk_clear_o = (state_q == ST_FETCH) && (idx_q == 3'd4);
  assign status_wr  = (state_q == ST_CLOSE) && !pk_pend_i;
  assign done_o     = status_wr && last_q;
  assign miss_o     = take && (state_q == ST_SUSP) && rx_last_i;
  assign drop_n     = take ? !rx_last_i : drop_q;
  assign state_o    = state_q;
  assign nxt_addr   = eor_q ? base_q : (chain_q ? next_q : cur_q + ADDR_W'(16));
  assign unused_w1  = {mem_rdata_i[31:16], mem_rdata_i[13:12], 14'd0};

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    pk_ack_o    = 1'b0;
    unique case (state_q)
      ST_FETCH: if (idx_q < 3'd4) begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + {{(ADDR_W-4){1'b0}}, idx_q[1:0], 2'b00};
      end
      ST_WRITE, ST_CLOSE: begin
        if (pk_pend_i) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = buf_q + {{(ADDR_W-BUF_SIZE_W){1'b0}}, pk_off_i};
          mem_wdata_o = pk_data_i;
          pk_ack_o    = 1'b1;
        end else if (state_q == ST_CLOSE) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = cur_q;
          mem_wdata_o = status_word(first_q, last_q, err_q, len_q);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_STOP;
      cur_q      <= '0;
      base_q     <= '0;
      buf_q      <= '0;
      next_q     <= '0;
      idx_q      <= '0;
      own_q      <= 1'b0;
      chain_q    <= 1'b0;
      eor_q      <= 1'b0;
      size_q     <= '0;
      in_frame_q <= 1'b0;
      first_q    <= 1'b0;
      last_q     <= 1'b0;
      err_q      <= 1'b0;
      drop_q     <= 1'b0;
      poll_q     <= 1'b0;
      len_q      <= '0;
    end else begin
      unique case (state_q)
        ST_STOP: if (run_i) begin
          base_q     <= base_i;
          cur_q      <= base_i;
          idx_q      <= '0;
          in_frame_q <= 1'b0;
          drop_q     <= 1'b0;
          poll_q     <= 1'b0;
          state_q    <= ST_FETCH;
        end
        ST_FETCH: begin
          idx_q <= idx_q + 3'd1;
          unique case (idx_q)
            3'd1: own_q <= mem_rdata_i[OWN_BIT];
            3'd2: begin
              size_q  <= mem_rdata_i[BUF_SIZE_W-1:0];
              chain_q <= mem_rdata_i[CHAIN_BIT];
              eor_q   <= mem_rdata_i[EOR_BIT];
            end
            3'd3: buf_q <= mem_rdata_i[ADDR_W-1:0];
            3'd4: begin
              next_q <= mem_rdata_i[ADDR_W-1:0];
              if (own_q) begin
                state_q <= in_frame_q ? ST_WRITE : ST_WAIT;
              end else begin
                drop_q     <= in_frame_q;
                in_frame_q <= 1'b0;
                poll_q     <= 1'b0;
                state_q    <= ST_SUSP;
              end
            end
            default: ;
          endcase
        end
        ST_WAIT: begin
          if (take) begin
            in_frame_q <= 1'b1;
            first_q    <= 1'b1;
            len_q      <= FRAME_LEN_W'(1);
            err_q      <= rx_err_i;
            if (rx_last_i || full) begin
              last_q  <= rx_last_i;
              state_q <= ST_CLOSE;
            end else begin
              state_q <= ST_WRITE;
            end
          end else if (!run_i) begin
            state_q <= ST_STOP;
          end
        end
        ST_WRITE: if (take) begin
          len_q <= len_q + FRAME_LEN_W'(1);
          err_q <= err_q | rx_err_i;
          if (rx_last_i || full) begin
            last_q  <= rx_last_i;
            state_q <= ST_CLOSE;
          end
        end
        ST_CLOSE: if (!pk_pend_i) begin
          cur_q   <= nxt_addr;
          idx_q   <= '0;
          first_q <= 1'b0;
          if (last_q) in_frame_q <= 1'b0;
          state_q <= ST_FETCH;
        end
        ST_SUSP: begin
          drop_q <= drop_n;
          if (!drop_n && !run_i) begin
            state_q <= ST_STOP;
          end else if (!drop_n && (poll_i || poll_q)) begin
            idx_q   <= '0;
            poll_q  <= 1'b0;
            state_q <= ST_FETCH;
          end else if (poll_i) begin
            poll_q <= 1'b1;
          end
        end
        default: state_q <= ST_STOP;
      endcase
    end
  end

  a_r8_unowned_suspends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) && (idx_q == 3'd4) && !own_q |=> state_q == ST_SUSP);
  a_r5_close_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_take_o && rx_last_i |=> state_q == ST_CLOSE);
  a_r12_idle_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) && !run_i && !rx_valid_i |=> state_q == ST_STOP);
  a_r10_no_write_suspended: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP) |-> !mem_req_o);
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              poll_i,
  input  logic [ADDR_W-1:0] list_base_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  output logic              rx_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic [2:0]        state_o,
  output logic              rx_irq_o,
  input  logic              irq_clr_i,
  output logic [MISS_W-1:0] missed_cnt_o
);
  logic                  pk_clear, pk_take, pk_force, pk_ack, pk_pend;
  logic [31:0]           pk_data;
  logic [BUF_SIZE_W-1:0] pk_off, pk_boff;
  logic                  done, miss;

  rxd_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk_i, .rst_ni, .run_i, .poll_i,
    .base_i      (list_base_i),
    .rx_valid_i, .rx_last_i, .rx_err_i, .rx_ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .state_o,
    .done_o      (done),
    .miss_o      (miss),
    .pk_clear_o  (pk_clear),
    .pk_take_o   (pk_take),
    .pk_force_o  (pk_force),
    .pk_ack_o    (pk_ack),
    .pk_pend_i   (pk_pend),
    .pk_data_i   (pk_data),
    .pk_off_i    (pk_off),
    .pk_boff_i   (pk_boff)
  );

  rxd_packer #(.SIZE_W(BUF_SIZE_W)) u_packer (
    .clk_i, .rst_ni,
    .clear_i     (pk_clear),
    .take_i      (pk_take),
    .byte_i      (rx_data_i),
    .force_i     (pk_force),
    .ack_i       (pk_ack),
    .pend_o      (pk_pend),
    .pend_data_o (pk_data),
    .pend_off_o  (pk_off),
    .boff_o      (pk_boff)
  );

  rxd_events #(.MISS_W(MISS_W)) u_events (
    .clk_i, .rst_ni,
    .done_i   (done),
    .clr_i    (irq_clr_i),
    .miss_i   (miss),
    .irq_o    (rx_irq_o),
    .missed_o (missed_cnt_o)
  );
endmodule

// File: tb/rx_desc_dma_test.sv
`timescale 1ns/1ps
module rx_desc_dma_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        run = 1'b0, poll = 1'b0, irq_clr = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready, mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  state;
  logic [15:0] missed;

  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:15];
  int rd_n = 0;
  int total = 0, bad = 0;

  localparam logic [31:0] BASE = 32'h100;
  localparam int BSIZE = 8;

  always #5 clk = ~clk;

  rx_desc_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .poll_i(poll), .list_base_i(BASE),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_err_i(rx_err),
    .rx_ready_o(rx_ready), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .state_o(state),
    .rx_irq_o(irq), .irq_clr_i(irq_clr), .missed_cnt_o(missed)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && !mem_we && rd_n < 16) begin
      rd_log[rd_n] = mem_addr;
      rd_n = rd_n + 1;
    end
  end

  function automatic logic [31:0] daddr(input int d);
    case (d)
      0: return 32'h100;
      1: return 32'h140;
      2: return 32'h180;
      default: return 32'h190;
    endcase
  endfunction

  function automatic logic [31:0] baddr(input int d);
    return 32'h200 + 32'(d) * 32'h40;
  endfunction

  function automatic logic [7:0] pat(input int l, input int i);
    return 8'((l * 7 + i * 13 + 1) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // d0,d1 chained; d2 contiguous; d3 end of ring (its chain bit and word3 must lose)
  task automatic arm(input int d, input logic own);
    logic [31:0] w1, w3;
    case (d)
      0: begin w1 = 32'(BSIZE) | (32'd1 << 14); w3 = 32'h140; end
      1: begin w1 = 32'(BSIZE) | (32'd1 << 14); w3 = 32'h180; end
      2: begin w1 = 32'(BSIZE);                 w3 = 32'h0BAD_0000; end
      default: begin w1 = 32'(BSIZE) | (32'd3 << 14); w3 = 32'h140; end
    endcase
    mem[daddr(d) >> 2]       <= own ? 32'h8000_0000 : 32'h0;
    mem[(daddr(d) >> 2) + 1] <= w1;
    mem[(daddr(d) >> 2) + 2] <= baddr(d);
    mem[(daddr(d) >> 2) + 3] <= w3;
    for (int w = 0; w < 16; w++) mem[(baddr(d) >> 2) + w] <= 32'hDEAD_BEEF;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last, input logic err);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input int l, input logic err);
    for (int i = 0; i < l; i++) send_byte(pat(l, i), i == l - 1, err && i == 0);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ci, segs, n, sus;
    logic [31:0] exp;
    for (int d = 0; d < 4; d++) arm(d, 1'b1);
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 state", 32'(state), 0);
    check("R1 ready", 32'(rx_ready), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 missed", 32'(missed), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle state", 32'(state), 0);
    check("R1 idle mem_req", 32'(mem_req), 0);
    rd_n = 0;
    run = 1'b1;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) check("R2 fetch addr", rd_log[k], BASE + 32'(4 * k));
    check("R9 wait code", 32'(state), 3);

    ci = 0;
    for (int l = 1; l <= 24; l++) begin
      logic err;
      err = (l % 5) == 0;
      for (int d = 0; d < 4; d++) arm(d, 1'b1);
      @(negedge clk);
      send_frame(l, err);
      repeat (16) @(negedge clk);
      segs = (l + BSIZE - 1) / BSIZE;
      for (int s = 0; s < segs; s++) begin
        int d;
        d = (ci + s) % 4;
        exp = (s == 0) ? (32'd1 << 9) : 32'd0;
        if (s == segs - 1) exp |= (32'd1 << 8) | (32'(l) << 16) | (32'(err) << 15);
        check("R5 R6 R7 writeback", mem[daddr(d) >> 2], exp);
        n = l - s * BSIZE;
        if (n > BSIZE) n = BSIZE;
        for (int w = 0; w < (n + 3) / 4; w++) begin
          exp = 0;
          for (int b = 0; b < 4; b++)
            if (w * 4 + b < n) exp |= 32'(pat(l, s * BSIZE + w * 4 + b)) << (8 * b);
          check("R4 data word", mem[(baddr(d) >> 2) + w], exp);
        end
        if (n == BSIZE) check("R3 buffer bound", mem[(baddr(d) >> 2) + 2], 32'hDEAD_BEEF);
      end
      check("R9 wait after frame", 32'(state), 3);
      check("R11 irq set", 32'(irq), 1);
      clear_irq();
      check("R11 irq cleared", 32'(irq), 0);
      ci = (ci + segs) % 4;
    end

    // suspend: hand every descriptor back to software
    for (int d = 0; d < 4; d++) arm(d, 1'b0);
    @(negedge clk);
    send_frame(3, 1'b0);
    repeat (16) @(negedge clk);
    check("R5 writeback before suspend", mem[daddr(ci) >> 2], (32'd3 << 8) | (32'd3 << 16));
    check("R8 suspended code", 32'(state), 4);
    clear_irq();
    sus = (ci + 1) % 4;
    send_frame(5, 1'b0);
    send_frame(5, 1'b1);
    repeat (4) @(negedge clk);
    check("R10 missed count", 32'(missed), 2);
    check("R10 desc untouched", mem[daddr(sus) >> 2], 0);
    check("R10 buffer untouched", mem[baddr(sus) >> 2], 32'hDEAD_BEEF);
    check("R10 no irq", 32'(irq), 0);
    mem[daddr(sus) >> 2] <= 32'h8000_0000;
    repeat (8) @(negedge clk);
    check("R8 stays suspended", 32'(state), 4);
    rd_n = 0;
    poll = 1'b1; @(negedge clk); poll = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 poll refetch addr", rd_log[0], daddr(sus));
    check("R8 resumes to wait", 32'(state), 3);
    run = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 stopped", 32'(state), 0);
    check("R12 ready low", 32'(rx_ready), 0);
    rd_n = 0;
    run = 1'b1;
    repeat (10) @(negedge clk);
    check("R2 restart from base", rd_log[0], BASE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule